// File: doc/BRIEF.md
# Flash erase and over-erase recovery sequencer

This block runs the full erase flow of an embedded flash module without processor help. After a start strobe it repeatedly verifies the selected address range at the erase-verify margin and applies whole-array erase pulses until every word reads all ones. It then checks a 32-word window for bits driven into depletion by the erase and, while any of those words reads non-zero, applies recovery (flash-write) pulses. It drives the module's control registers through a write-only register port and reads the array through a read port with one cycle of latency.

Each verify pass walks the range in ascending order. For every word it first reads the bitwise complement of the address, discards that data, and then reads the address itself. This forces every address line to toggle before each compared read, which is the worst case for the array's decode path. A pass stops at the first failing word, because one failure is enough to require another pulse. Pulse widths, settle delays and both pulse limits are parameters. When a limit is used up, the block stops the module, raises its error output and returns to idle.

Top module: `flash_erase_recover`

## Requirements
- R1: After reset the block is idle: busy, done and error are 0, array_mode is 1, and neither rd_en nor reg_we is asserted. A start pulse while idle raises busy in the next cycle and clears error.
- R2: Before every erase pulse, 16'hFFFF is written to the write-data register (reg_sel 3). The control register (reg_sel 0) is then written with segment enables [15:8] equal to prot_mask, mode field [2:1] = 01 and execute bit [0] = 0. Next the same word is written with bit 0 set. Bit 0 is cleared again no sooner than ERASE_PULSE_CYC cycles later.
- R3: Each erase verify pass writes control 16'h0010 (verify-1 bit 4 alone). Then, for each address from first_addr upward, it reads the AW-bit complement of the address and, in the next cycle, the address itself. Only the data of the second read is compared.
- R4: The erase succeeds only when a verify pass finds every word from first_addr to last_addr equal to 16'hFFFF. Any other value ends the pass, and exactly one further erase pulse follows.
- R5: At most MAX_ERASE erase pulses are applied. A verify pass that still fails after that many pulses ends in failure.
- R6: The depletion check writes control 16'h0018 (bits 4 and 3) and reads WINDOW words starting at first_addr. It passes only when all of them read 16'h0000.
- R7: A recovery pulse writes control with [15:8] = 8'hFF and mode [2:1] = 10, then sets bit 0 and holds it for at least FW_PULSE_CYC cycles. After each recovery pulse the depletion check starts again at first_addr.
- R8: At most MAX_FW recovery pulses are applied. A depletion check that still fails after that many pulses ends in failure.
- R9: Every run ends with a control write of 0 and a single-cycle done pulse, after which busy is 0. error is 1 on either failure path and 0 on success, and it holds its value until the next start.
- R10: Register writes happen only while array_mode is 0 (register access), and array reads only while array_mode is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, taken only while idle |
| prot_mask | input | 8 | Segment enables used for erase pulses |
| first_addr | input | AW | First address of the range; base of the depletion window |
| last_addr | input | AW | Last address of the erase range |
| reg_we | output | 1 | Register write strobe |
| reg_sel | output | 2 | Register select: 0 control, 3 write data |
| reg_wdata | output | 16 | Register write value |
| array_mode | output | 1 | 1 = array access, 0 = register access |
| rd_en | output | 1 | Array read request |
| rd_addr | output | AW | Array read address |
| rd_data | input | 16 | Read data, valid the cycle after rd_en |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Last run failed |

## Verification
The embedded assertions check the cycle-local rules on every cycle: the write-data load before each erase arm, the arm-then-execute write pair, all segments enabled for recovery pulses, the complement read immediately before every compared verify read, the pulse counters never passing their limits, the width of the done pulse, and the split between array mode and register mode. Pulse counts, how long the execute bit stays high, the verify pass that stops at the first bad word, the restart of the window after each recovery pulse, and both failure outcomes depend on how the array responds over many passes. Only the bench's flash model scenarios can show those.

// File: rtl/fer_pkg.sv
// Package: shared constants, state type and control-word builder for the
// flash erase/recovery sequencer.
// Assumes: 16-bit registers; control word layout is decoded by the flash
// module's register file, so field positions are fixed here.
package fer_pkg;

    localparam int unsigned DW = 16;

    // Register select codes on the register port
    localparam logic [1:0] REG_CTRL  = 2'd0;
    localparam logic [1:0] REG_WDATA = 2'd3;

    // Mode field values (control bits [2:1])
    localparam logic [1:0] MODE_NONE   = 2'b00;
    localparam logic [1:0] MODE_ERASE  = 2'b01;
    localparam logic [1:0] MODE_FWRITE = 2'b10;

    typedef enum logic [4:0] {
        S_IDLE,
        S_WAIT,
        S_EV_SET,
        S_E_RDC,
        S_E_RDA,
        S_E_CHK,
        S_E_STOP,
        S_E_WD,
        S_E_ARM,
        S_E_EXE,
        S_E_OFF,
        S_D_SET,
        S_D_RD,
        S_D_CHK,
        S_D_STOP,
        S_F_ARM,
        S_F_EXE,
        S_F_OFF,
        S_PASS,
        S_FAIL
    } seq_state_t;

    // Build a control word: [15:8] segments, [4] verify-1, [3] verify-0,
    // [2:1] mode, [0] execute
    function automatic logic [DW-1:0] ctrl_word(input logic [7:0] seg,
                                                input logic       v1,
                                                input logic       v0,
                                                input logic [1:0] mode,
                                                input logic       exe);
        return {seg, 3'b000, v1, v0, mode, exe};
    endfunction

endpackage

// File: rtl/fer_delay.sv
// Module: down-counting delay timer.
// Loading sets the count; it then decrements to zero and stays there.
// Assumes: load has priority; expired is high whenever the count is zero.
module fer_delay #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    // Count register: load, else decrement toward zero
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // A drained timer stays drained until reloaded (supports R2, R7 widths)
    p_hold_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/fer_pulse_ctr.sv
// Module: pulse counter with a fixed limit.
// Counts applied pulses since the last clear and flags when LIMIT is reached.
// Assumes: the caller never increments once at_limit is high.
module fer_pulse_ctr #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);

    localparam int unsigned W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    // Counter register: clear on start, step on each pulse
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (inc)    cnt_q <= cnt_q + 1'b1;
    end

    assign at_limit = (cnt_q >= W'(LIMIT));

    // Pulse count never passes the limit (R5 for erase, R8 for recovery)
    p_count_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(LIMIT));

endmodule

// File: rtl/flash_erase_recover.sv
// Module: erase and over-erase recovery sequencer for one flash module.
// Verifies the range at the verify-1 margin with complement-first reads,
// applies erase pulses until all words read FFFFh, then checks a window at
// the inverse-erase margin and applies recovery pulses until it reads 0000h.
// Assumes: rd_data is valid the cycle after rd_en; register writes take
// effect at the clock edge they are issued on; WINDOW is a power of two.
module flash_erase_recover
    import fer_pkg::*;
#(
    parameter int unsigned AW              = 14,
    parameter int unsigned WINDOW          = 32,
    parameter int unsigned ERASE_PULSE_CYC = 1_400_000,
    parameter int unsigned FW_PULSE_CYC    = 20_000,
    parameter int unsigned SETTLE_CYC      = 2_000,
    parameter int unsigned MAX_ERASE       = 1000,
    parameter int unsigned MAX_FW          = 10000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    prot_mask,
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    output logic          reg_we,
    output logic [1:0]    reg_sel,
    output logic [15:0]   reg_wdata,
    output logic          array_mode,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [15:0]   rd_data,
    output logic          busy,
    output logic          done,
    output logic          error
);

    localparam int unsigned DLY1 = (ERASE_PULSE_CYC > FW_PULSE_CYC) ? ERASE_PULSE_CYC : FW_PULSE_CYC;
    localparam int unsigned DMAX = (DLY1 > SETTLE_CYC) ? DLY1 : SETTLE_CYC;
    localparam int unsigned CW   = $clog2(DMAX + 1);
    localparam int unsigned WIW  = (WINDOW > 1) ? $clog2(WINDOW) : 1;

    seq_state_t    state_q, state_d, ret_q, ret_d;
    logic [AW-1:0] cur_q, cur_d, first_q, last_q;
    logic [WIW-1:0] win_q, win_d;
    logic [7:0]    prot_q;
    logic          err_q;
    logic          t_load, t_exp;
    logic [CW-1:0] t_val;
    logic          e_inc, f_inc, cnt_clr, e_lim, f_lim;

    fer_delay #(.CW(CW)) u_delay (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
    );

    fer_pulse_ctr #(.LIMIT(MAX_ERASE)) u_erase_ctr (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(e_inc), .at_limit(e_lim)
    );

    fer_pulse_ctr #(.LIMIT(MAX_FW)) u_fw_ctr (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(f_inc), .at_limit(f_lim)
    );

    // Sequencer registers: state, return state, cursors, latched request, error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ret_q   <= S_IDLE;
            cur_q   <= '0;
            win_q   <= '0;
            first_q <= '0;
            last_q  <= '0;
            prot_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
            cur_q   <= cur_d;
            win_q   <= win_d;
            if (state_q == S_IDLE && start) begin
                first_q <= first_addr;
                last_q  <= last_addr;
                prot_q  <= prot_mask;
                err_q   <= 1'b0;
            end else if (state_d == S_FAIL && state_q != S_FAIL) begin
                err_q   <= 1'b1;
            end
        end
    end

    // Next-state and port decode for each step of the erase/recovery flow
    always_comb begin
        state_d   = state_q;
        ret_d     = ret_q;
        cur_d     = cur_q;
        win_d     = win_q;
        reg_we    = 1'b0;
        reg_sel   = REG_CTRL;
        reg_wdata = '0;
        rd_en     = 1'b0;
        rd_addr   = cur_q;
        t_load    = 1'b0;
        t_val     = '0;
        e_inc     = 1'b0;
        f_inc     = 1'b0;
        cnt_clr   = 1'b0;
        unique case (state_q)
            S_IDLE: if (start) begin
                cnt_clr = 1'b1;
                state_d = S_EV_SET;
            end
            S_WAIT: if (t_exp) state_d = ret_q;
            S_EV_SET: begin
                reg_we    = 1'b1;
                reg_wdata = ctrl_word(8'h00, 1'b1, 1'b0, MODE_NONE, 1'b0);
                t_load    = 1'b1;
                t_val     = CW'(SETTLE_CYC);
                cur_d     = first_q;
                ret_d     = S_E_RDC;
                state_d   = S_WAIT;
            end
            S_E_RDC: begin
                rd_en   = 1'b1;
                rd_addr = ~cur_q;
                state_d = S_E_RDA;
            end
            S_E_RDA: begin
                rd_en   = 1'b1;
                state_d = S_E_CHK;
            end
            S_E_CHK: begin
                if (rd_data != 16'hFFFF)   state_d = S_E_STOP;
                else if (cur_q == last_q)  state_d = S_D_SET;
                else begin
                    cur_d   = cur_q + 1'b1;
                    state_d = S_E_RDC;
                end
            end
            S_E_STOP: begin
                reg_we  = 1'b1;
                state_d = e_lim ? S_FAIL : S_E_WD;
            end
            S_E_WD: begin
                reg_we    = 1'b1;
                reg_sel   = REG_WDATA;
                reg_wdata = 16'hFFFF;
                state_d   = S_E_ARM;
            end
            S_E_ARM: begin
                reg_we    = 1'b1;
                reg_wdata = ctrl_word(prot_q, 1'b0, 1'b0, MODE_ERASE, 1'b0);
                state_d   = S_E_EXE;
            end
            S_E_EXE: begin
                reg_we    = 1'b1;
                reg_wdata = ctrl_word(prot_q, 1'b0, 1'b0, MODE_ERASE, 1'b1);
                t_load    = 1'b1;
                t_val     = CW'(ERASE_PULSE_CYC);
                e_inc     = 1'b1;
                ret_d     = S_E_OFF;
                state_d   = S_WAIT;
            end
            S_E_OFF: begin
                reg_we  = 1'b1;
                state_d = S_EV_SET;
            end
            S_D_SET: begin
                reg_we    = 1'b1;
                reg_wdata = ctrl_word(8'h00, 1'b1, 1'b1, MODE_NONE, 1'b0);
                t_load    = 1'b1;
                t_val     = CW'(SETTLE_CYC);
                win_d     = '0;
                ret_d     = S_D_RD;
                state_d   = S_WAIT;
            end
            S_D_RD: begin
                rd_en   = 1'b1;
                rd_addr = first_q + AW'(win_q);
                state_d = S_D_CHK;
            end
            S_D_CHK: begin
                if (rd_data != 16'h0000)              state_d = S_D_STOP;
                else if (win_q == WIW'(WINDOW - 1))   state_d = S_PASS;
                else begin
                    win_d   = win_q + 1'b1;
                    state_d = S_D_RD;
                end
            end
            S_D_STOP: begin
                reg_we  = 1'b1;
                state_d = f_lim ? S_FAIL : S_F_ARM;
            end
            S_F_ARM: begin
                reg_we    = 1'b1;
                reg_wdata = ctrl_word(8'hFF, 1'b0, 1'b0, MODE_FWRITE, 1'b0);
                state_d   = S_F_EXE;
            end
            S_F_EXE: begin
                reg_we    = 1'b1;
                reg_wdata = ctrl_word(8'hFF, 1'b0, 1'b0, MODE_FWRITE, 1'b1);
                t_load    = 1'b1;
                t_val     = CW'(FW_PULSE_CYC);
                f_inc     = 1'b1;
                ret_d     = S_F_OFF;
                state_d   = S_WAIT;
            end
            S_F_OFF: begin
                reg_we  = 1'b1;
                state_d = S_D_SET;
            end
            S_PASS, S_FAIL: begin
                reg_we  = 1'b1;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign busy       = (state_q != S_IDLE);
    assign done       = (state_q == S_PASS) || (state_q == S_FAIL);
    assign error      = err_q;
    assign array_mode = (state_q == S_IDLE)  || (state_q == S_E_RDC) ||
                        (state_q == S_E_RDA) || (state_q == S_E_CHK) ||
                        (state_q == S_D_RD)  || (state_q == S_D_CHK);

    // R2: an erase arm write is directly preceded by the FFFFh data load
    p_wdata_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == REG_CTRL && reg_wdata[2:1] == MODE_ERASE && !reg_wdata[0])
        |-> $past(reg_we && reg_sel == REG_WDATA && reg_wdata == 16'hFFFF));

    // R2, R7: an execute write repeats the previous write with bit 0 added
    p_arm_then_exe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == REG_CTRL && reg_wdata[0])
        |-> ($past(reg_we) && $past(reg_sel) == REG_CTRL &&
             $past(reg_wdata) == {reg_wdata[15:1], 1'b0}));

    // R7: recovery writes enable every segment
    p_seg_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == REG_CTRL && reg_wdata[2:1] == MODE_FWRITE)
        |-> (reg_wdata[15:8] == 8'hFF));

    // R3: each compared verify read follows a read of the complemented address
    p_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_E_RDA) |-> ($past(rd_en) && $past(rd_addr) == ~rd_addr));

    // R9: done lasts one cycle and the block is idle afterwards
    p_done_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9: a failure end carries the error flag
    p_fail_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FAIL) |-> error);

    // R10: register writes only in register mode, reads only in array mode
    p_mode_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !array_mode);
    p_mode_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> array_mode);

endmodule

// File: tb/flash_erase_recover_test.sv
// Bench: directed scenarios against a behavioural flash model that responds
// to the control register shadow (verify-1 / inverse-erase margins).
module flash_erase_recover_test;

    localparam int unsigned AW = 8;
    localparam int unsigned EP = 20;
    localparam int unsigned FP = 12;
    localparam int unsigned ME = 4;
    localparam int unsigned MF = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    prot_mask = '0;
    logic [AW-1:0] first_addr = '0, last_addr = '0;
    logic          reg_we, array_mode, rd_en, busy, done, error;
    logic [1:0]    reg_sel;
    logic [15:0]   reg_wdata, rd_data;
    logic [AW-1:0] rd_addr;

    always #2.5 clk = ~clk;

    flash_erase_recover #(
        .AW(AW), .WINDOW(32), .ERASE_PULSE_CYC(EP), .FW_PULSE_CYC(FP),
        .SETTLE_CYC(3), .MAX_ERASE(ME), .MAX_FW(MF)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .prot_mask(prot_mask),
        .first_addr(first_addr), .last_addr(last_addr),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .array_mode(array_mode), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .done(done), .error(error)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    // flash model state
    int ep, fp, need_e, need_f;
    logic [AW-1:0] lag, base;
    logic [15:0] ctrl_sh = '0, wd_sh = '0;
    // monitor results
    int n_real, n_dread, bad_wd, bad_seg, bad_pair, bad_win, bad_restart, bad_mode;
    int min_edur, min_fdur, exe_t;
    logic phase, restart;
    logic [AW-1:0] prev_a;

    function automatic logic [15:0] model(input logic [AW-1:0] a, input logic [15:0] c);
        if (c == 16'h0010)
            return (ep >= ((a == lag) ? need_e : 1)) ? 16'hFFFF : 16'h0F0F;
        else if (c == 16'h0018)
            return (a == AW'(base + 31) && fp < need_f) ? 16'h0004 : 16'h0000;
        return 16'hDEAD;
    endfunction

    // Array read port model, one cycle latency
    always @(posedge clk) if (rd_en) rd_data <= model(rd_addr, ctrl_sh);

    // Port monitor: pulses, shadows, read ordering, window and mode rules
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if ((reg_we && array_mode) || (rd_en && !array_mode)) bad_mode++;
            if (reg_we && reg_sel == 2'd3) wd_sh <= reg_wdata;
            if (reg_we && reg_sel == 2'd0) begin
                ctrl_sh <= reg_wdata;
                if (reg_wdata[0] && reg_wdata[2:1] == 2'b01) begin
                    ep++; exe_t = cyc;
                    if (wd_sh != 16'hFFFF) bad_wd++;
                    if (reg_wdata[15:8] != prot_mask) bad_seg++;
                end
                if (reg_wdata[0] && reg_wdata[2:1] == 2'b10) begin
                    fp++; exe_t = cyc; restart = 1'b1;
                    if (reg_wdata[15:8] != 8'hFF) bad_seg++;
                end
                if (!reg_wdata[0] && ctrl_sh[0]) begin
                    if (ctrl_sh[2:1] == 2'b01 && (cyc - exe_t) < min_edur) min_edur = cyc - exe_t;
                    if (ctrl_sh[2:1] == 2'b10 && (cyc - exe_t) < min_fdur) min_fdur = cyc - exe_t;
                    wd_sh <= 16'h0000;
                end
            end
            if (rd_en && ctrl_sh == 16'h0010) begin
                if (!phase) begin prev_a = rd_addr; phase = 1'b1; end
                else begin
                    if (rd_addr != ~prev_a) bad_pair++;
                    n_real++; phase = 1'b0;
                end
            end
            if (rd_en && ctrl_sh == 16'h0018) begin
                n_dread++;
                if (AW'(rd_addr - base) >= AW'(32)) bad_win++;
                if (restart && rd_addr != base) bad_restart++;
                restart = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) if (cyc > 150000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        finish_run();
    end

    // Launch one sequence and wait for its done pulse
    task automatic run(input logic [7:0] pm, input logic [AW-1:0] fa, input logic [AW-1:0] la,
                       input logic [AW-1:0] lg, input int ne, input int nf,
                       output int err_seen, output int busy_after);
        ep = 0; fp = 0; need_e = ne; need_f = nf; lag = lg; base = fa;
        n_real = 0; n_dread = 0; bad_wd = 0; bad_seg = 0; bad_pair = 0;
        bad_win = 0; bad_restart = 0; bad_mode = 0;
        min_edur = 1 << 30; min_fdur = 1 << 30; phase = 1'b0; restart = 1'b0;
        @(negedge clk);
        prot_mask = pm; first_addr = fa; last_addr = la; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1", "busy after start", int'(busy), 1);
        err_seen = -1;
        for (int i = 0; i < 20000; i++) begin
            if (done) begin err_seen = int'(error); break; end
            @(negedge clk);
        end
        chk("R9", "done seen", int'(err_seen >= 0), 1);
        @(negedge clk);
        busy_after = int'(busy);
        chk("R9", "done width one", int'(done), 0);
        chk("R9", "control stopped", int'(ctrl_sh), 0);
        chk("R10", "array mode at end", int'(array_mode), 1);
        chk("R10", "mode violations", bad_mode, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset busy", int'(busy), 0);
        chk("R1", "reset done", int'(done), 0);
        chk("R1", "reset error", int'(error), 0);
        chk("R1", "reset array_mode", int'(array_mode), 1);
        chk("R1", "reset strobes", int'(rd_en | reg_we), 0);
    endtask

    task automatic t_clean_erase();
        int e, b;
        run(8'hA5, 8'h00, 8'hFF, 8'hFF, 2, 0, e, b);
        chk("R9", "clean error", e, 0);
        chk("R9", "clean busy after", b, 0);
        chk("R4", "erase pulses", ep, 2);
        chk("R4", "compared verify reads", n_real, 1 + 256 + 256);
        chk("R3", "complement pairing", bad_pair, 0);
        chk("R2", "wdata loaded per pulse", bad_wd, 0);
        chk("R2", "segment enables", bad_seg, 0);
        chk("R2", "erase width ok", int'(min_edur >= EP), 1);
        chk("R6", "window reads", n_dread, 32);
        chk("R6", "no recovery pulse", fp, 0);
    endtask

    task automatic t_depletion();
        int e, b;
        run(8'hFF, 8'h40, 8'hBF, 8'h40, 1, 3, e, b);
        chk("R7", "recovery success", e, 0);
        chk("R4", "single erase pulse", ep, 1);
        chk("R3", "compared reads", n_real, 1 + 128);
        chk("R7", "recovery pulses", fp, 3);
        chk("R7", "all segments", bad_seg, 0);
        chk("R7", "recovery width ok", int'(min_fdur >= FP), 1);
        chk("R7", "window restart", bad_restart, 0);
        chk("R6", "window bounds", bad_win, 0);
        chk("R6", "window reads", n_dread, 4 * 32);
    endtask

    task automatic t_erase_limit();
        int e, b;
        run(8'h0F, 8'h00, 8'hFF, 8'hFF, 99, 0, e, b);
        chk("R5", "erase fail error", e, 1);
        chk("R5", "erase pulses at cap", ep, ME);
        chk("R5", "no recovery", fp, 0);
    endtask

    task automatic t_fw_limit();
        int e, b;
        run(8'hFF, 8'h10, 8'h3F, 8'h10, 1, 99, e, b);
        chk("R8", "recovery fail error", e, 1);
        chk("R8", "recovery pulses at cap", fp, MF);
        repeat (5) @(negedge clk);
        chk("R9", "error held while idle", int'(error), 1);
    endtask

    task automatic t_single_word();
        int e, b;
        run(8'h01, 8'h33, 8'h33, 8'h33, 1, 0, e, b);
        chk("R1", "error cleared by new start", e, 0);
        chk("R3", "single word compared reads", n_real, 2);
        chk("R3", "single word pairing", bad_pair, 0);
        chk("R6", "window from first address", bad_win, 0);
    endtask

    initial begin
        t_reset();
        t_clean_erase();
        t_depletion();
        t_erase_limit();
        t_fw_limit();
        t_single_word();
        finish_run();
    end

endmodule